// File: doc/BRIEF.md
# 100Base-TX Transmit Scrambler and MLT-3 Line Coder

This block sits between the 4B/5B encoder and the analog line driver of a 100 Mb/s twisted-pair transmitter. It accepts one 5-bit code-group per five bit times, whether the group is Idle, a start or end delimiter, or data. It sends the group out one bit at a time, most significant bit first. Every serial bit is XORed with the keystream of a free-running linear feedback shift register. The scrambled bit then drives an NRZI level and a three-level MLT-3 symbol for the driver.

The bit rate is given by a clock enable, `bit_en`, on the block's clock. The block keeps its own five-slot position counter. It raises `cg_take` in the enabled cycle that samples `cg_data`, so the upstream encoder presents the next group in that cycle. All three outputs are registered and change on the clock edge where the bit is consumed.

Top module: `tx_line_coder`

## Requirements
- R1: `cg_take` is high exactly in cycles where `bit_en` is high and the serializer is at the first of its five bit slots. After reset the first enabled cycle is slot one, and slots advance only on enabled cycles.
- R2: `cg_data` is sampled only in a `cg_take` cycle. Its bits are sent as bit 4, 3, 2, 1, 0 on that enabled cycle and the next four enabled cycles. Changes on `cg_data` during the other slots have no effect on the outputs.
- R3: The keystream comes from an 11-stage register s[10:0] loaded with SEED (default 11'h7FF). On each enabled cycle the key is s[10] XOR s[8], the register becomes {s[9:0], key}, and `scr_bit` takes serial bit XOR key. This holds for every group, Idle and delimiters included.
- R4: On each enabled cycle `nrzi_lvl` inverts when the new scrambled bit is 1 and holds when it is 0.
- R5: Each scrambled 1 moves the line through the cycle 0, +1, 0, −1, 0 … and a scrambled 0 holds the level. `mlt_sym` encodes 0 as 2'b00, +1 as 2'b01 and −1 as 2'b11, and it never shows 2'b10.
- R6: In a cycle with `bit_en` low, none of `scr_bit`, `nrzi_lvl`, `mlt_sym`, the slot position or the keystream changes, and `cg_take` is low.
- R7: Synchronous active-high `rst` reloads SEED, returns the slot to the first position, and clears `scr_bit`, `nrzi_lvl` and `mlt_sym`. The MLT-3 cycle restarts at the zero that precedes +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate clock enable |
| cg_data | input | 5 | Code-group from the 4B/5B encoder |
| cg_take | output | 1 | Code-group sampled this cycle |
| scr_bit | output | 1 | Last scrambled NRZ bit |
| nrzi_lvl | output | 1 | NRZI line level |
| mlt_sym | output | 2 | MLT-3 symbol: 00 zero, 01 plus, 11 minus |

## Verification
The bench builds the block with its default parameters: 5-bit code-groups, an 11-stage keystream with its second tap at stage 9, and an all-ones seed. This default seed puts the first enabled key bit at zero, so the reset-to-first-bit path is checked against a known value. It also leads to long runs in which the key changes the serial pattern, and those runs drive the MLT-3 level through every phase of its cycle. Groups are sent back-to-back and with idle enable gaps. Wrong-valued `cg_data` is presented during the non-sampling slots. A reset mid-group shows the seed reload and the slot realignment.

// File: rtl/txl_pkg.sv
package txl_pkg;

    localparam int unsigned CG_BITS = 5;

    typedef logic [1:0] mlt_sym_t;

    localparam mlt_sym_t SYM_ZERO = 2'b00;
    localparam mlt_sym_t SYM_POS  = 2'b01;
    localparam mlt_sym_t SYM_NEG  = 2'b11;

    // Position inside the four-step MLT-3 cycle
    typedef enum logic [1:0] {
        MP_ZERO_RISE = 2'd0,
        MP_POS       = 2'd1,
        MP_ZERO_FALL = 2'd2,
        MP_NEG       = 2'd3
    } mlt_phase_e;

    typedef struct packed {
        logic       nrzi;
        mlt_phase_e phase;
    } line_state_t;

    localparam line_state_t LINE_RESET = '{nrzi: 1'b0, phase: MP_ZERO_RISE};

    function automatic mlt_phase_e mlt_advance(input mlt_phase_e p);
        case (p)
            MP_ZERO_RISE: return MP_POS;
            MP_POS:       return MP_ZERO_FALL;
            MP_ZERO_FALL: return MP_NEG;
            default:      return MP_ZERO_RISE;
        endcase
    endfunction

    function automatic mlt_sym_t mlt_encode(input mlt_phase_e p);
        case (p)
            MP_POS:  return SYM_POS;
            MP_NEG:  return SYM_NEG;
            default: return SYM_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/txl_serializer.sv
module txl_serializer #(
    parameter int unsigned CG_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_en,
    input  logic [CG_W-1:0] cg_data,
    output logic            cg_take,
    output logic            ser_bit
);
    localparam int unsigned CNT_W = (CG_W > 2) ? $clog2(CG_W) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(CG_W - 1);

    logic [CNT_W-1:0] slot_q;
    logic [CG_W-2:0]  rest_q;

    assign cg_take = bit_en && (slot_q == '0);
    assign ser_bit = (slot_q == '0) ? cg_data[CG_W-1] : rest_q[CG_W-2];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            rest_q <= '0;
        end else if (bit_en) begin
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
            if (slot_q == '0) begin
                rest_q <= cg_data[CG_W-2:0];
            end else begin
                rest_q <= {rest_q[CG_W-3:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/txl_keystream.sv
module txl_keystream #(
    parameter int unsigned LFSR_W = 11,
    parameter int unsigned TAP_B  = 9,
    parameter logic [LFSR_W-1:0] SEED = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    output logic key_bit
);
    logic [LFSR_W-1:0] state_q;

    assign key_bit = state_q[LFSR_W-1] ^ state_q[TAP_B-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (bit_en) begin
            state_q <= {state_q[LFSR_W-2:0], key_bit};
        end
    end
endmodule

// File: rtl/txl_line_coder.sv
module txl_line_coder
    import txl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     scr_in,
    output logic     scr_bit,
    output logic     nrzi_lvl,
    output mlt_sym_t mlt_sym
);
    line_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (scr_in) begin
            st_d.nrzi  = ~st_q.nrzi;
            st_d.phase = mlt_advance(st_q.phase);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LINE_RESET;
            scr_bit <= 1'b0;
        end else if (bit_en) begin
            st_q    <= st_d;
            scr_bit <= scr_in;
        end
    end

    assign nrzi_lvl = st_q.nrzi;
    assign mlt_sym  = mlt_encode(st_q.phase);
endmodule

// File: rtl/tx_line_coder.sv
module tx_line_coder #(
    parameter int unsigned CG_W   = 5,
    parameter int unsigned LFSR_W = 11,
    parameter int unsigned TAP_B  = 9,
    parameter logic [LFSR_W-1:0] SEED = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_en,
    input  logic [CG_W-1:0] cg_data,
    output logic            cg_take,
    output logic            scr_bit,
    output logic            nrzi_lvl,
    output logic [1:0]      mlt_sym
);
    logic ser_bit;
    logic key_bit;
    logic scr_raw;

    txl_serializer #(.CG_W(CG_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .cg_data (cg_data),
        .cg_take (cg_take),
        .ser_bit (ser_bit)
    );

    txl_keystream #(.LFSR_W(LFSR_W), .TAP_B(TAP_B), .SEED(SEED)) u_key (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .key_bit (key_bit)
    );

    assign scr_raw = ser_bit ^ key_bit;

    txl_line_coder u_line (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .scr_in   (scr_raw),
        .scr_bit  (scr_bit),
        .nrzi_lvl (nrzi_lvl),
        .mlt_sym  (mlt_sym)
    );
endmodule

// File: rtl/txl_checker.sv
module txl_checker #(
    parameter int unsigned CG_W = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       cg_take,
    input logic       scr_bit,
    input logic       nrzi_lvl,
    input logic [1:0] mlt_sym
);
    localparam int unsigned CW = (CG_W > 2) ? $clog2(CG_W) : 1;
    logic [CW-1:0] slot_cnt;

    always_ff @(posedge clk) begin
        if (rst) slot_cnt <= '0;
        else if (bit_en) slot_cnt <= (slot_cnt == CW'(CG_W - 1)) ? '0 : slot_cnt + 1'b1;
    end

    p_take_slot_r1: assert property (@(posedge clk) disable iff (rst)
        cg_take == (bit_en && slot_cnt == '0));

    p_nrzi_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> ((nrzi_lvl != $past(nrzi_lvl)) == scr_bit));

    p_mlt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> (scr_bit || $stable(mlt_sym)));

    p_mlt_via_zero_r5: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> (!scr_bit || ((mlt_sym == 2'b00) != ($past(mlt_sym) == 2'b00))));

    p_mlt_legal_r5: assert property (@(posedge clk) disable iff (rst)
        mlt_sym != 2'b10);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(scr_bit) && $stable(nrzi_lvl) && $stable(mlt_sym)));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!scr_bit && !nrzi_lvl && mlt_sym == 2'b00));
endmodule

bind tx_line_coder txl_checker #(.CG_W(CG_W)) u_txl_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .cg_take  (cg_take),
    .scr_bit  (scr_bit),
    .nrzi_lvl (nrzi_lvl),
    .mlt_sym  (mlt_sym)
);

// File: tb/test_tx_line_coder.sv
module test_tx_line_coder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [4:0] cg;
        logic       gap;
    } vec_t;

    // Idle, J, K, data, T, R, Idle run, with enable gaps on some groups
    localparam vec_t VEC [NVEC] = '{
        '{5'b11111, 1'b0}, '{5'b11111, 1'b0}, '{5'b11000, 1'b0}, '{5'b10001, 1'b1},
        '{5'b11110, 1'b0}, '{5'b01001, 1'b0}, '{5'b10100, 1'b1}, '{5'b01101, 1'b0},
        '{5'b00111, 1'b0}, '{5'b11111, 1'b1}, '{5'b00000, 1'b0}, '{5'b11111, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [4:0] cg_data = 5'd0;
    logic       cg_take, scr_bit, nrzi_lvl;
    logic [1:0] mlt_sym;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench reference state
    logic [10:0] m_lfsr;
    logic [4:0]  m_word;
    int          m_slot;
    logic        m_scr, m_nrzi;
    int          m_ph;

    tx_line_coder i_tx_line_coder (
        .clk(clk), .rst(rst), .bit_en(bit_en), .cg_data(cg_data),
        .cg_take(cg_take), .scr_bit(scr_bit), .nrzi_lvl(nrzi_lvl), .mlt_sym(mlt_sym)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] enc(input int ph);
        return (ph == 1) ? 2'b01 : (ph == 3) ? 2'b11 : 2'b00;
    endfunction

    task automatic model_reset();
        m_lfsr = 11'h7FF; m_slot = 0; m_scr = 1'b0; m_nrzi = 1'b0; m_ph = 0; m_word = '0;
    endtask

    task automatic check_outputs(input string tag);
        chk(scr_bit == m_scr, {tag, " R3 scr_bit"}, scr_bit, m_scr);
        chk(nrzi_lvl == m_nrzi, {tag, " R4 nrzi_lvl"}, nrzi_lvl, m_nrzi);
        chk(mlt_sym == enc(m_ph), {tag, " R5 mlt_sym"}, mlt_sym, enc(m_ph));
    endtask

    // one clock: drive at negedge, check take before the edge, outputs after
    task automatic tick(input logic en, input logic [4:0] cg, input string tag);
        logic bit_v, key;
        @(negedge clk);
        bit_en = en; cg_data = cg;
        #1;
        chk(cg_take == (en && m_slot == 0), {tag, " R1 cg_take"}, cg_take, en && m_slot == 0);
        if (en) begin
            if (m_slot == 0) m_word = cg;                 // R2 sample only at take
            bit_v = m_word[4 - m_slot];                   // R2 msb first
            key = m_lfsr[10] ^ m_lfsr[8];                 // R3
            m_lfsr = {m_lfsr[9:0], key};
            m_scr = bit_v ^ key;
            if (m_scr) begin m_nrzi = ~m_nrzi; m_ph = (m_ph + 1) % 4; end
            m_slot = (m_slot + 1) % 5;
        end
        @(posedge clk); #1;
        check_outputs(tag);
    endtask

    task automatic send_group(input logic [4:0] cg, input logic gap, input string tag);
        for (int b = 0; b < 5; b++) begin
            // during later slots present the complement: R2 says it is ignored
            tick(1'b1, (b == 0) ? cg : ~cg, tag);
            if (gap) begin
                tick(1'b0, 5'b10101, {tag, " R6 gap"});
                tick(1'b0, 5'b01010, {tag, " R6 gap"});
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R7 reset state
        check_outputs("reset R7");
        tick(1'b0, 5'b11111, "post-reset R6");

        // table walk
        for (int v = 0; v < NVEC; v++)
            send_group(VEC[v].cg, VEC[v].gap, $sformatf("vec%0d", v));

        // long idle run exercises all MLT-3 phases (R5)
        for (int k = 0; k < 20; k++) send_group(5'b11111, 1'b0, "idle run R3");

        // mid-group reset: R7 seed reload and slot realignment
        tick(1'b1, 5'b10110, "pre-reset");
        tick(1'b1, 5'b01001, "pre-reset");
        @(negedge clk); rst = 1'b1; bit_en = 1'b1;
        @(posedge clk); #1;
        model_reset();
        check_outputs("mid reset R7");
        @(negedge clk); rst = 1'b0; bit_en = 1'b0;
        #1;
        chk(cg_take == 1'b0, "R6 take low when disabled", cg_take, 0);
        send_group(5'b11000, 1'b0, "after reset R7");
        send_group(5'b10001, 1'b1, "after reset R2");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule